// File: doc/BRIEF.md
# Chained Seven-Segment Wipe Sequencer

This block plays a staged blank-out animation across four seven-segment digits. Out of reset every digit shows all seven segments lit. A start pulse arms the animation. Each step-enable tick then advances it by one step.

The animation works on one digit at a time, starting with digit 0. The active digit switches its segments off one per tick in a clockwise sweep. When that digit is fully dark, the next digit begins its own sweep. After the last digit goes dark, a sticky done flag is raised so that a later display stage can take over.

The tick sets the animation rate and is generated outside the block. A segment bit of 1 means the segment is lit.

Top module: `seg_wipe_seq`

## Requirements
- R1: A synchronous active-low reset, sampled on the rising clock edge, makes every digit show 7'h7F (all segments lit) and clears the done flag. This holds whether the animation was idle, running or finished.
- R2: Before a start pulse, ticks have no effect, so all digits stay at 7'h7F and done stays 0.
- R3: For the active digit, consecutive ticks produce 7'h7E, 7'h5E, 7'h1E, 7'h1C, 7'h18, 7'h10 and 7'h00 in that order. Bit 6 is the leftmost bit. The segment bus updates on the clock edge that samples the tick.
- R4: At most one digit at a time shows a partial pattern. Digits that have not begun yet show 7'h7F.
- R5: The tick after the active digit reaches 7'h00 hands the animation to the next digit, which keeps 7'h7F for that tick. A digit that has finished stays at 7'h00. The digits animate in the order 0, 1, 2, 3, so each digit needs 8 ticks.
- R6: The done flag rises on the 32nd tick after start, with all digits at 7'h00. It then stays high, and the digits stay dark, through further ticks until reset or a new start.
- R7: A start pulse while the animation is running is ignored, and the sweep continues unchanged.
- R8: A start pulse while idle or done begins a new run. It sets all digits to 7'h7F and clears done on that edge. A tick in the same cycle as an accepted start does not advance the sweep.
- R9: In cycles with no tick and no start, the outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins a run |
| tick_i | input | 1 | Step enable, advances the sweep by one step |
| seg_o | output | 4x7 | Segment buses, index d is digit d, 1 = lit |
| done_o | output | 1 | High once all digits are dark |

## Verification
The sweep is driven with back-to-back ticks and also with ticks separated by idle cycles. Back-to-back ticks expose any lag of one edge in the registered outputs. The idle gaps show that nothing moves without a tick.

Each of the 32 steps is compared against a model that counts ticks, which separates a wrong pattern order from a wrong handoff point between digits. Further cases cover a start during a run, which must not disturb the sweep, and a restart from done, which must relight every digit. Ticks before start and a reset in mid-run check that the idle state is truly inert.

// File: rtl/wipe_pkg.sv
// Package: shared widths and the clockwise sweep table for the wipe sequencer.
// Assumes a 7-segment digit and a 3-bit sweep step; a bit value of 1 means lit.
package wipe_pkg;
    localparam int SEG_W  = 7;
    localparam int STEP_W = 3;
    localparam logic [SEG_W-1:0] SEG_LIT  = 7'h7F;
    localparam logic [SEG_W-1:0] SEG_DARK = 7'h00;

    // Maps a sweep step to its pattern; step 0 is fully lit, steps 7..1 drop one segment each.
    function automatic logic [SEG_W-1:0] sweep_pattern(input logic [STEP_W-1:0] step);
        logic [SEG_W-1:0] pat;
        case (step)
            3'd7:    pat = 7'b1111110;
            3'd6:    pat = 7'b1011110;
            3'd5:    pat = 7'b0011110;
            3'd4:    pat = 7'b0011100;
            3'd3:    pat = 7'b0011000;
            3'd2:    pat = 7'b0010000;
            3'd1:    pat = 7'b0000000;
            default: pat = SEG_LIT;
        endcase
        return pat;
    endfunction
endpackage

// File: rtl/wipe_ctrl.sv
// Module: wipe_ctrl
// Holds the shared digit index, the step counter, the run state and the done flag.
// Exposes the next-state values so digit registers update on the same edge.
// Assumes NUM_DIGITS >= 2; the step runs 0, 7, 6, ..., 1 and then hands off.
module wipe_ctrl #(
    parameter int NUM_DIGITS = 4,
    localparam int IDX_W = $clog2(NUM_DIGITS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic                       tick_i,
    output logic [IDX_W-1:0]           nxt_idx_o,
    output logic [wipe_pkg::STEP_W-1:0] nxt_step_o,
    output logic                       nxt_done_o,
    output logic                       done_o
);
    import wipe_pkg::*;

    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(NUM_DIGITS - 1);
    localparam logic [STEP_W-1:0] STEP_TOP  = '1;
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(1);

    logic [IDX_W-1:0]  idx_q,  idx_d;
    logic [STEP_W-1:0] step_q, step_d;
    logic              run_q,  run_d;
    logic              done_q, done_d;

    // Next-state: accept start when not running, otherwise advance on tick.
    always_comb begin
        idx_d  = idx_q;
        step_d = step_q;
        run_d  = run_q;
        done_d = done_q;
        if (start_i && !run_q) begin
            idx_d  = '0;
            step_d = '0;
            run_d  = 1'b1;
            done_d = 1'b0;
        end else if (run_q && tick_i) begin
            if (step_q == '0) begin
                step_d = STEP_TOP;
            end else if (step_q == STEP_LAST) begin
                step_d = '0;
                if (idx_q == LAST_IDX) begin
                    run_d  = 1'b0;
                    done_d = 1'b1;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end else begin
                step_d = step_q - 1'b1;
            end
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            step_q <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            idx_q  <= idx_d;
            step_q <= step_d;
            run_q  <= run_d;
            done_q <= done_d;
        end
    end

    assign nxt_idx_o  = idx_d;
    assign nxt_step_o = step_d;
    assign nxt_done_o = done_d;
    assign done_o     = done_q;
endmodule

// File: rtl/wipe_digit.sv
// Module: wipe_digit
// Registered segment bus for one digit at position DIG_ID.
// It is dark once the sequence has passed it, plays the sweep table while
// active, and stays lit before its turn. Assumes the inputs are next-state values.
module wipe_digit #(
    parameter int NUM_DIGITS = 4,
    parameter int DIG_ID     = 0,
    localparam int IDX_W = $clog2(NUM_DIGITS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [IDX_W-1:0]            nxt_idx_i,
    input  logic [wipe_pkg::STEP_W-1:0] nxt_step_i,
    input  logic                        nxt_done_i,
    output logic [wipe_pkg::SEG_W-1:0]  seg_o
);
    import wipe_pkg::*;

    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(DIG_ID);

    logic [SEG_W-1:0] seg_d;

    // Choose this digit's pattern from its position relative to the active index.
    always_comb begin
        if (nxt_done_i || (nxt_idx_i > MY_IDX)) begin
            seg_d = SEG_DARK;
        end else if (nxt_idx_i == MY_IDX) begin
            seg_d = sweep_pattern(nxt_step_i);
        end else begin
            seg_d = SEG_LIT;
        end
    end

    // Output register, lit after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_o <= SEG_LIT;
        end else begin
            seg_o <= seg_d;
        end
    end
endmodule

// File: rtl/seg_wipe_seq.sv
// Module: seg_wipe_seq (top)
// Four-digit staged blank-out: one controller shared by a row of digit registers.
// Assumes tick_i is a one-cycle enable produced elsewhere; 1 = lit segment.
module seg_wipe_seq #(
    parameter int NUM_DIGITS = 4,
    localparam int IDX_W = $clog2(NUM_DIGITS)
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        start_i,
    input  logic                                        tick_i,
    output logic [NUM_DIGITS-1:0][wipe_pkg::SEG_W-1:0]  seg_o,
    output logic                                        done_o
);
    import wipe_pkg::*;

    logic [IDX_W-1:0]  nxt_idx;
    logic [STEP_W-1:0] nxt_step;
    logic              nxt_done;

    wipe_ctrl #(.NUM_DIGITS(NUM_DIGITS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .tick_i     (tick_i),
        .nxt_idx_o  (nxt_idx),
        .nxt_step_o (nxt_step),
        .nxt_done_o (nxt_done),
        .done_o     (done_o)
    );

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
        wipe_digit #(.NUM_DIGITS(NUM_DIGITS), .DIG_ID(g)) u_digit (
            .clk        (clk),
            .rst_n      (rst_n),
            .nxt_idx_i  (nxt_idx),
            .nxt_step_i (nxt_step),
            .nxt_done_i (nxt_done),
            .seg_o      (seg_o[g])
        );
    end
endmodule

// File: rtl/seg_wipe_seq_chk.sv
// Module: seg_wipe_seq_chk
// Port-level properties of the wipe sequencer, attached to the top module by bind.
module seg_wipe_seq_chk #(
    parameter int NUM_DIGITS = 4
) (
    input logic                                       clk,
    input logic                                       rst_n,
    input logic                                       start_i,
    input logic                                       tick_i,
    input logic [NUM_DIGITS-1:0][wipe_pkg::SEG_W-1:0] seg_o,
    input logic                                       done_o
);
    import wipe_pkg::*;

    logic [NUM_DIGITS-1:0] partial;
    logic                  all_dark;
    logic                  all_lit;

    // Flag digits with a partial pattern and summarise the whole row.
    always_comb begin
        all_dark = 1'b1;
        all_lit  = 1'b1;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            partial[i] = (seg_o[i] != SEG_DARK) && (seg_o[i] != SEG_LIT);
            if (seg_o[i] != SEG_DARK) all_dark = 1'b0;
            if (seg_o[i] != SEG_LIT)  all_lit  = 1'b0;
        end
    end

    AST_RESET_LIT: assert property (@(posedge clk) !rst_n |=> (all_lit && !done_o)); // R1
    AST_ONE_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n) $countones(partial) <= 1); // R4
    AST_DONE_DARK: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> all_dark); // R6
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (done_o && !start_i) |=> done_o); // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!tick_i && !start_i) |=> ($stable(seg_o) && $stable(done_o))); // R9

    for (genvar g = 1; g < NUM_DIGITS; g++) begin : g_order
        AST_ORDER: assert property (@(posedge clk) disable iff (!rst_n) (seg_o[g] != SEG_LIT) |-> (seg_o[g-1] == SEG_DARK)); // R5
    end
endmodule

bind seg_wipe_seq seg_wipe_seq_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .tick_i  (tick_i),
    .seg_o   (seg_o),
    .done_o  (done_o)
);

// File: tb/seg_wipe_seq_bench.sv
// Directed bench for seg_wipe_seq; one task for each scenario, each checks its own results.
module seg_wipe_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ND = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic tick_i = 1'b0;
    logic [ND-1:0][6:0] seg_o;
    logic done_o;

    int n_run = 0;
    int n_fail = 0;
    int ticks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_wipe_seq #(.NUM_DIGITS(ND)) u_seg_wipe_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(tick_i),
        .seg_o(seg_o), .done_o(done_o)
    );

    // Sweep table by tick position within a digit (R3).
    function automatic logic [6:0] tab(input int pos);
        case (pos)
            0: return 7'h7F;
            1: return 7'h7E;
            2: return 7'h5E;
            3: return 7'h1E;
            4: return 7'h1C;
            5: return 7'h18;
            6: return 7'h10;
            default: return 7'h00;
        endcase
    endfunction

    // Expected digit i after n ticks since start.
    function automatic logic [6:0] exp_seg(input int i, input int n);
        if (n >= 8*ND) return 7'h00;
        if (i < n/8) return 7'h00;
        if (i == n/8) return tab(n % 8);
        return 7'h7F;
    endfunction

    // One clock: drive at the falling edge, then sample just after the rising edge.
    task automatic cyc(input logic st, input logic tk);
        @(negedge clk);
        start_i = st;
        tick_i  = tk;
        @(posedge clk);
        #1;
        start_i = 1'b0;
        tick_i  = 1'b0;
    endtask

    // Compare all digits and done against the tick-count model.
    task automatic chk(input int n, input string req);
        logic [ND-1:0][6:0] e;
        logic ed;
        for (int i = 0; i < ND; i++) e[i] = exp_seg(i, n);
        ed = (n >= 8*ND);
        n_run++;
        if (seg_o !== e || done_o !== ed) begin
            n_fail++;
            $display("FAIL %s: n=%0d seg=%h done=%b expected seg=%h done=%b", req, n, seg_o, done_o, e, ed);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b1);
        rst_n = 1'b1;
        chk(0, "R1 reset");
    endtask

    task automatic t_idle_ticks();
        for (int k = 0; k < 5; k++) cyc(1'b0, 1'b1);
        chk(0, "R2 ticks before start");
    endtask

    task automatic t_full_sweep_gapped();
        cyc(1'b1, 1'b1);
        ticks = 0;
        chk(0, "R8 start with tick does not advance");
        for (int k = 0; k < 8*ND; k++) begin
            cyc(1'b0, 1'b1);
            ticks++;
            chk(ticks, (ticks % 8 == 0) ? "R5 handoff" : "R3 sweep step");
            cyc(1'b0, 1'b0);
            chk(ticks, "R9 hold without tick");
        end
        chk(ticks, "R6 done raised");
        for (int k = 0; k < 4; k++) cyc(1'b0, 1'b1);
        chk(8*ND, "R6 done held under ticks");
    endtask

    task automatic t_restart_back_to_back();
        cyc(1'b1, 1'b0);
        ticks = 0;
        chk(0, "R8 restart relights");
        for (int k = 0; k < 12; k++) begin
            cyc(1'b0, 1'b1);
            ticks++;
            chk(ticks, "R3 R4 back-to-back");
        end
        cyc(1'b1, 1'b1);
        ticks++;
        chk(ticks, "R7 start during run ignored");
        cyc(1'b1, 1'b0);
        chk(ticks, "R7 lone start during run ignored");
        for (int k = 0; k < 8*ND - 13; k++) begin
            cyc(1'b0, 1'b1);
            ticks++;
        end
        chk(ticks, "R6 done after 32 ticks");
    endtask

    task automatic t_reset_mid();
        cyc(1'b1, 1'b0);
        for (int k = 0; k < 11; k++) cyc(1'b0, 1'b1);
        chk(11, "R4 mid-run state");
        do_reset();
        t_idle_ticks();
    endtask

    initial begin
        do_reset();
        t_idle_ticks();
        t_full_sweep_gapped();
        t_restart_back_to_back();
        t_reset_mid();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: expired, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule